// File: doc/BRIEF.md
# Compare, Negate, Extend and Test-Set Unit

This block is a small ALU slice for a processor datapath. It executes five operations on byte, word or longword data: compare, two's-complement negate, zero extension, sign extension, and a test-and-set on a byte. Each request carries two 32-bit operands, an operation code, a size code and, for extensions, a source-width bit. The unit returns a 32-bit result, a write-enable that says whether the result should be stored, and four condition flags (negative, zero, overflow, carry/borrow).

Requests enter on a valid/ready channel and results leave on a second valid/ready channel behind a single output register. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. This gives one result per cycle at full throughput. While `out_valid` is high and `out_ready` is low, the result, write-enable and flags are held and no new request is taken. A requester must hold its request fields steady until it is accepted.

The flags are state kept inside the unit. They change only when a request is accepted, so an operation that leaves a flag unchanged keeps the value from the previous accepted request. For test-and-set, the byte to be tested arrives on `in_opa` and the modified byte leaves on `res_data`. This forms the read-modify-write exchange; any bus locking is the requester's concern.

Top module: `cnext_unit`

## Requirements
- R1: A request is accepted on an edge with `in_valid` and `in_ready` high. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `res_data`, `res_we` and the flags stay unchanged.
- R2: `in_op` encodes 0 = compare, 1 = negate, 2 = zero-extend, 3 = sign-extend, 4 = test-and-set. `in_size` encodes 0 = byte (bits 7:0), 1 = word (bits 15:0), 2 = longword (bits 31:0). A result has its active-size bits replaced, and bits above the active size are copied from `in_opa`.
- R3: Compare evaluates `in_opa − in_opb` at the active size and updates all four flags. `res_we` is 0 and `res_data` equals `in_opa`.
- R4: Negate produces `0 − in_opa` at the active size with `res_we` = 1.
- R5: For compare and negate, N is the top bit of the difference at the active size, and Z is 1 when all active-size bits of the difference are zero.
- R6: For compare and negate, C is the borrow out of the active-size subtraction and V is its signed overflow. Negating the most negative value (0x80, 0x8000, 0x80000000) gives that same value with V = 1 and N = 1.
- R7: Zero extension takes the low 8 bits (`in_src_word` = 0) or low 16 bits (`in_src_word` = 1) of `in_opa` and fills the rest of the active size with zeros. The legal pairs are byte→word, byte→longword and word→longword.
- R8: Sign extension uses the same legal pairs as R7 but fills the remaining active-size bits with the source's top bit (bit 7 or bit 15).
- R9: A legal extension sets N to the result's top bit at the active size, sets Z when the active-size result is zero, clears V, and leaves C unchanged.
- R10: An extension with an illegal pair (size byte, word from word, or size 3), a compare or negate with size 3, or an op code 5 to 7 gives `res_we` = 0 and `res_data` = `in_opa`, and leaves all four flags unchanged.
- R11: Test-and-set ignores `in_size`. It returns `in_opa` with bit 7 forced to 1, sets `res_we` = 1, takes N from bit 7 of the original byte and Z from the original byte being zero, clears V, and leaves C unchanged.
- R12: After reset `out_valid` is 0, `in_ready` is 1 and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Active (destination) size code |
| in_src_word | input | 1 | Extension source width: 0 byte, 1 word |
| in_opa | input | 32 | Destination operand / byte to test |
| in_opb | input | 32 | Source operand for compare |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 32 | Result value |
| res_we | output | 1 | Result is to be written back |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry/borrow flag |

## Verification
The assertions assume that the request fields are known (not X) whenever `in_valid` is high. They also assume a requester keeps them steady until the handshake completes, because the hold checks compare registered outputs across stalled cycles. The stimulus drives every input on the falling edge and keeps a request unchanged while it waits. It walks every op code, size code and source-width value against a set of edge operands: zero, all-ones, and the signed limits at each size. A stalled phase checks that a held request is taken only once the output drains.

// File: rtl/cnext_pkg.sv
package cnext_pkg;

  localparam int DATA_W  = 32;
  localparam int LANES   = 3;   // byte, word, longword
  localparam int SIZE_W  = 2;
  localparam int OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_CMP  = 3'd0,
    OP_NEG  = 3'd1,
    OP_EXTU = 3'd2,
    OP_EXTS = 3'd3,
    OP_TAS  = 3'd4
  } op_e;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  function automatic logic [DATA_W-1:0] size_mask(input logic [SIZE_W-1:0] s);
    case (s)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_top(input logic [SIZE_W-1:0] s);
    case (s)
      2'd0:    return 32'h0000_0080;
      2'd1:    return 32'h0000_8000;
      default: return 32'h8000_0000;
    endcase
  endfunction

endpackage

// File: rtl/cnext_sub.sv
module cnext_sub
  import cnext_pkg::*;
(
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  input  logic [SIZE_W-1:0] size,
  output logic [DATA_W-1:0] diff,
  output logic              dn,
  output logic              dz,
  output logic              dv,
  output logic              dc
);

  logic [DATA_W-1:0] lane_d [LANES];
  logic [LANES-1:0]  lane_c;
  logic [LANES-1:0]  lane_v;
  logic [LANES-1:0]  lane_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int W = 8 << g;
    logic [W:0] d;
    assign d         = {1'b0, minuend[W-1:0]} - {1'b0, subtrahend[W-1:0]};
    assign lane_d[g] = DATA_W'(d[W-1:0]);
    assign lane_c[g] = d[W];
    assign lane_n[g] = d[W-1];
    assign lane_v[g] = (minuend[W-1] ^ subtrahend[W-1]) & (minuend[W-1] ^ d[W-1]);
  end

  logic [1:0] sel;
  assign sel = (size == 2'd0) ? 2'd0 : (size == 2'd1) ? 2'd1 : 2'd2;

  assign diff = lane_d[sel];
  assign dn   = lane_n[sel];
  assign dc   = lane_c[sel];
  assign dv   = lane_v[sel];
  assign dz   = (lane_d[sel] == '0);

endmodule

// File: rtl/cnext_ext.sv
module cnext_ext
  import cnext_pkg::*;
(
  input  logic [DATA_W-1:0] opa,
  input  logic [SIZE_W-1:0] dst_size,
  input  logic              src_word,
  input  logic              sign_fill,
  output logic [DATA_W-1:0] ext_res,
  output logic              legal,
  output logic              en,
  output logic              ez
);

  logic [DATA_W-1:0] src_mask;
  logic [DATA_W-1:0] low;
  logic [DATA_W-1:0] filled;
  logic [DATA_W-1:0] dmask;
  logic              src_top;

  assign src_mask = src_word ? 32'h0000_FFFF : 32'h0000_00FF;
  assign src_top  = src_word ? opa[15] : opa[7];
  assign low      = opa & src_mask;
  assign filled   = (sign_fill && src_top) ? (low | ~src_mask) : low;
  assign dmask    = size_mask(dst_size);

  assign legal   = (dst_size == SZ_LONG) || (dst_size == SZ_WORD && !src_word);
  assign ext_res = (opa & ~dmask) | (filled & dmask);
  assign en      = |(filled & size_top(dst_size));
  assign ez      = ((filled & dmask) == '0);

endmodule

// File: rtl/cnext_tas.sv
module cnext_tas (
  input  logic [7:0] byte_in,
  output logic [7:0] byte_out,
  output logic       tn,
  output logic       tz
);

  assign byte_out = {1'b1, byte_in[6:0]};
  assign tn       = byte_in[7];
  assign tz       = (byte_in == 8'h00);

endmodule

// File: rtl/cnext_unit.sv
module cnext_unit
  import cnext_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic              in_src_word,
  input  logic [31:0]       in_opa,
  input  logic [31:0]       in_opb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       res_data,
  output logic              res_we,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);

  flags_t            flags_q;
  flags_t            nxt_flags;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_we;
  logic              accept;

  // shared subtractor: compare (a - b) and negate (0 - a)
  logic              is_neg;
  logic [DATA_W-1:0] sub_x;
  logic [DATA_W-1:0] sub_y;
  logic [DATA_W-1:0] sub_d;
  logic              sub_n, sub_z, sub_v, sub_c;

  assign is_neg = (in_op == OP_NEG);
  assign sub_x  = is_neg ? '0 : in_opa;
  assign sub_y  = is_neg ? in_opa : in_opb;

  cnext_sub u_sub (
    .minuend    (sub_x),
    .subtrahend (sub_y),
    .size       (in_size),
    .diff       (sub_d),
    .dn         (sub_n),
    .dz         (sub_z),
    .dv         (sub_v),
    .dc         (sub_c)
  );

  logic [DATA_W-1:0] ext_res;
  logic              ext_legal, ext_n, ext_z;

  cnext_ext u_ext (
    .opa       (in_opa),
    .dst_size  (in_size),
    .src_word  (in_src_word),
    .sign_fill (in_op == OP_EXTS),
    .ext_res   (ext_res),
    .legal     (ext_legal),
    .en        (ext_n),
    .ez        (ext_z)
  );

  logic [7:0] tas_byte;
  logic       tas_n, tas_z;

  cnext_tas u_tas (
    .byte_in  (in_opa[7:0]),
    .byte_out (tas_byte),
    .tn       (tas_n),
    .tz       (tas_z)
  );

  logic [DATA_W-1:0] cur_mask;
  logic              size_ok;
  assign cur_mask = size_mask(in_size);
  assign size_ok  = (in_size != SZ_BAD);

  always_comb begin
    nxt_res   = in_opa;
    nxt_we    = 1'b0;
    nxt_flags = flags_q;
    case (in_op)
      OP_CMP: begin
        if (size_ok) nxt_flags = '{n: sub_n, z: sub_z, v: sub_v, c: sub_c};
      end
      OP_NEG: begin
        if (size_ok) begin
          nxt_res   = (in_opa & ~cur_mask) | (sub_d & cur_mask);
          nxt_we    = 1'b1;
          nxt_flags = '{n: sub_n, z: sub_z, v: sub_v, c: sub_c};
        end
      end
      OP_EXTU, OP_EXTS: begin
        if (ext_legal) begin
          nxt_res   = ext_res;
          nxt_we    = 1'b1;
          nxt_flags = '{n: ext_n, z: ext_z, v: 1'b0, c: flags_q.c};
        end
      end
      OP_TAS: begin
        nxt_res   = {in_opa[31:8], tas_byte};
        nxt_we    = 1'b1;
        nxt_flags = '{n: tas_n, z: tas_z, v: 1'b0, c: flags_q.c};
      end
      default: ;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_data  <= '0;
      res_we    <= 1'b0;
      flags_q   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      res_data  <= nxt_res;
      res_we    <= nxt_we;
      flags_q   <= nxt_flags;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;
  assign flag_c = flags_q.c;

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_data) && $stable(res_we) && $stable(flags_q)));

  // R3
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_CMP) |=> !res_we);

  // R6
  neg_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_NEG && in_size == SZ_BYTE && in_opa[7:0] == 8'h80)
      |=> (flag_v && flag_n && res_data[7:0] == 8'h80));

  // R9
  ext_keep_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op == OP_EXTU || in_op == OP_EXTS)) |=> (flag_c == $past(flag_c)));

  // R9
  ext_clear_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op == OP_EXTU || in_op == OP_EXTS) && ext_legal) |=> !flag_v);

  // R11
  tas_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_TAS) |=> (res_we && res_data[7]));

  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op > 3'd4) |=> (!res_we && $stable(flags_q)));

endmodule

// File: tb/cnext_unit_tb.sv
module cnext_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic        in_src_word = 1'b0;
  logic [31:0] in_opa = '0;
  logic [31:0] in_opb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] res_data;
  logic        res_we;
  logic        flag_n, flag_z, flag_v, flag_c;

  int checks = 0;
  int fails  = 0;
  logic [3:0] mflags = 4'b0000;  // n z v c

  always #2 clk = ~clk;

  cnext_unit dut_i (
    .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_size, .in_src_word,
    .in_opa, .in_opb, .out_valid, .out_ready, .res_data, .res_we,
    .flag_n, .flag_z, .flag_v, .flag_c
  );

  logic [31:0] pats [12] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_007F, 32'h0000_0080,
                             32'h0000_00FF, 32'h0000_7FFF, 32'h0000_8000, 32'h0000_FFFF,
                             32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_A5C3};

  task automatic check(input bit ok, input string tag, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference model, built from the requirements
  task automatic model(input logic [2:0] op, input logic [1:0] sz, input logic sw,
                       input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] er, output logic ewe, output logic [3:0] ef);
    logic [31:0] m, sb, r, sm, ssb, e;
    m  = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    sb = (sz == 2'd0) ? 32'h80 : (sz == 2'd1) ? 32'h8000 : 32'h8000_0000;
    er = a; ewe = 1'b0; ef = mflags;
    case (op)
      3'd0: if (sz != 2'd3) begin
        r  = (a - b) & m;
        ef = {(r & sb) != 0, r == 0, ((a ^ b) & (a ^ r) & sb) != 0, (a & m) < (b & m)};
      end
      3'd1: if (sz != 2'd3) begin
        r   = (32'd0 - a) & m;
        er  = (a & ~m) | r;
        ewe = 1'b1;
        ef  = {(r & sb) != 0, r == 0, (a & m) == sb, (a & m) != 0};
      end
      3'd2, 3'd3: if ((sz == 2'd1 && !sw) || sz == 2'd2) begin
        sm  = sw ? 32'hFFFF : 32'hFF;
        ssb = sw ? 32'h8000 : 32'h80;
        e   = a & sm;
        if (op == 3'd3 && (a & ssb) != 0) e = e | (m & ~sm);
        er  = (a & ~m) | e;
        ewe = 1'b1;
        ef  = {(e & sb) != 0, e == 0, 1'b0, mflags[0]};
      end
      3'd4: begin
        er  = a | 32'h80;
        ewe = 1'b1;
        ef  = {a[7], a[7:0] == 8'h00, 1'b0, mflags[0]};
      end
      default: ;
    endcase
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic ewe);
    if (op > 3'd4 || (op != 3'd0 && !ewe)) return "R10";
    case (op)
      3'd0: return "R3 R5 R6 R2";
      3'd1: return "R4 R5 R6 R2";
      3'd2: return "R7 R9 R2";
      3'd3: return "R8 R9 R2";
      default: return "R11";
    endcase
  endfunction

  task automatic run_one(input logic [2:0] op, input logic [1:0] sz, input logic sw,
                         input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er; logic ewe; logic [3:0] ef;
    model(op, sz, sw, a, b, er, ewe, ef);
    @(negedge clk);
    in_op = op; in_size = sz; in_src_word = sw; in_opa = a; in_opb = b;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && res_we == ewe && res_data == er && {flag_n, flag_z, flag_v, flag_c} == ef,
          tag_of(op, ewe),
          {out_valid, res_we, flag_n, flag_z, flag_v, flag_c, res_data},
          {1'b1, ewe, ef, er});
    mflags = ef;
  endtask

  bit done = 1'b0;

  initial begin
    logic [31:0] er1, er2; logic w1, w2; logic [3:0] f1, f2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12
    check(!out_valid && in_ready && {flag_n, flag_z, flag_v, flag_c} == 4'b0 && !res_we, "R12",
          {out_valid, res_we, flag_n, flag_z, flag_v, flag_c, 31'b0},
          {1'b0, 1'b0, 4'b0, 31'b0});
    rst_n = 1'b1;

    for (int op = 0; op < 8; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int sw = 0; sw < 2; sw++)
          for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
              if (op == 0 || j == 0)
                run_one(3'(op), 2'(sz), 1'(sw), pats[i], pats[(i + j) % 12]);

    // R1: back-pressure, with a second request held while stalled
    model(3'd1, 2'd1, 1'b0, 32'hABCD_0001, 32'h0, er1, w1, f1);
    mflags = f1;
    model(3'd4, 2'd0, 1'b0, 32'h0000_0000, 32'h0, er2, w2, f2);
    mflags = f2;
    @(negedge clk);
    in_op = 3'd1; in_size = 2'd1; in_src_word = 1'b0; in_opa = 32'hABCD_0001; in_opb = '0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_op = 3'd4; in_size = 2'd0; in_opa = 32'h0000_0000;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(out_valid && !in_ready && res_data == er1 && res_we == w1 &&
            {flag_n, flag_z, flag_v, flag_c} == f1, "R1 stall hold",
            {out_valid, res_we, flag_n, flag_z, flag_v, flag_c, res_data},
            {1'b1, w1, f1, er1});
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && res_data == er2 && res_we == w2 && {flag_n, flag_z, flag_v, flag_c} == f2,
          "R1 release R11", {out_valid, res_we, flag_n, flag_z, flag_v, flag_c, res_data},
          {1'b1, w2, f2, er2});
    @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready, "R1 drain", {out_valid, in_ready, 35'b0}, {1'b0, 1'b1, 35'b0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule